// File: doc/BRIEF.md
# Receive DMA Error Offset Tracker

This block sits beside a receive DMA channel that drains bytes into two memory buffers, A and B, filled in turn. Each byte arrives with the parity and framing flags it was stored with. For each buffer the block keeps a running byte offset and records the offset of the first byte whose flags show an error. Software can then find the first bad character in a finished buffer without scanning it.

A per-buffer start strobe begins a new fill of that buffer. It zeroes the buffer's offset and forgets any error it had captured. A separate sticky flag records a receiver overrun that happens while the DMA channel is enabled. Address generation and the memory interface belong to the DMA engine, not to this block.

Top module: `rxe_err_ofs_trk`

## Requirements
- R1: Each buffer has an offset counter. A transfer strobe with `buf_sel_i`=0 targets buffer A (index 0) and `buf_sel_i`=1 targets buffer B (index 1). Each such transfer occupies the current offset of its buffer and advances that counter by one.
- R2: A transferred byte is erroneous when its parity flag, its framing flag or both are set. The first erroneous byte in a buffer sets that buffer's valid bit and loads its offset. Both are visible on the outputs one clock after the transfer.
- R3: Once a buffer's valid bit is set, later erroneous bytes into that buffer change neither its valid bit nor its offset.
- R4: A start strobe for a buffer clears its valid bit and offset and restarts its counter at zero. If a transfer into the same buffer falls in the same cycle as its start, that byte sits at offset 0, and if it is erroneous it is captured at offset 0.
- R5: Transfers and starts aimed at one buffer leave the other buffer's valid bit and offset unchanged.
- R6: A captured offset of 0 shows valid=1. A buffer with no error shows valid=0, so the two cases can be told apart.
- R7: An overrun event while `dma_en_i` is high sets `rx_ovf_o` on the next clock. An overrun event while `dma_en_i` is low has no effect.
- R8: `rx_ovf_o` stays set until `dma_en_i` goes from low to high. In a cycle that has both that rising edge and an overrun event, the flag is set.
- R9: The offset counter holds at BUF_DEPTH-1 (63 by default). Bytes past the end of the buffer that are erroneous are captured at that offset.
- R10: After reset all outputs are zero. Error flags presented without `xfer_vld_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dma_en_i | input | 1 | Receive DMA channel enabled |
| xfer_vld_i | input | 1 | One byte moved to memory this cycle |
| par_err_i | input | 1 | Parity error flag of that byte |
| frm_err_i | input | 1 | Framing error flag of that byte |
| buf_sel_i | input | 1 | Active buffer: 0 = A, 1 = B |
| buf_start_i | input | 2 | Start new fill, bit 0 = A, bit 1 = B |
| ovf_evt_i | input | 1 | Receiver overrun event |
| err_vld_o | output | 2 | First error captured, bit 0 = A, bit 1 = B |
| err_ofs_o | output | 2*OFS_W | Captured offsets, A in low OFS_W bits |
| rx_ovf_o | output | 1 | Sticky overrun-during-DMA flag |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a buffer's start strobe and an erroneous transfer into that same buffer. The bench drives them together and expects valid=1 at offset 0, with the counter then continuing from 1. The second pair is the rising edge of `dma_en_i` and an overrun event. The bench provokes that cycle and expects the flag to be set, not cleared. The bench also starts one buffer while a bad byte goes to the other, and expects each buffer to follow only its own stimulus.

// File: rtl/rxe_pkg.sv
package rxe_pkg;
  localparam int unsigned NBUF = 2;
  localparam int unsigned SEL_W = 1;

  typedef struct packed {
    logic vld;
    logic par;
    logic frm;
  } rxe_xfer_t;

  function automatic logic xfer_bad(rxe_xfer_t x);
    return x.par | x.frm;
  endfunction
endpackage

// File: rtl/rxe_ofs_cnt.sv
module rxe_ofs_cnt #(
  parameter int unsigned BUF_DEPTH = 64,
  localparam int unsigned OFS_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  output logic [OFS_W-1:0] cnt_o
);
  localparam logic [OFS_W-1:0] CNT_MAX = OFS_W'(BUF_DEPTH - 1);

  logic [OFS_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i) begin
      cnt_d = (step_i && CNT_MAX != '0) ? OFS_W'(1) : '0;
    end else if (step_i && cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + OFS_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rxe_first_cap.sv
module rxe_first_cap #(
  parameter int unsigned OFS_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  input  logic             bad_i,
  input  logic [OFS_W-1:0] cnt_i,
  output logic             vld_o,
  output logic [OFS_W-1:0] ofs_o
);
  logic             vld_q, vld_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic             hit;

  assign hit = step_i & bad_i;

  always_comb begin
    vld_d = vld_q;
    ofs_d = ofs_q;
    if (start_i) begin
      // byte in the start cycle lands at offset 0
      vld_d = hit;
      ofs_d = '0;
    end else if (hit && !vld_q) begin
      vld_d = 1'b1;
      ofs_d = cnt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ofs_q <= '0;
    end else begin
      vld_q <= vld_d;
      ofs_q <= ofs_d;
    end
  end

  assign vld_o = vld_q;
  assign ofs_o = ofs_q;
endmodule

// File: rtl/rxe_ovf_flag.sv
module rxe_ovf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dma_en_i,
  input  logic ovf_evt_i,
  output logic ovf_o
);
  logic en_q, ovf_q, ovf_d, en_rise;

  assign en_rise = dma_en_i & ~en_q;

  always_comb begin
    ovf_d = ovf_q;
    if (dma_en_i && ovf_evt_i) ovf_d = 1'b1;
    else if (en_rise)          ovf_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      en_q  <= dma_en_i;
      ovf_q <= ovf_d;
    end
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/rxe_err_ofs_trk.sv
module rxe_err_ofs_trk #(
  parameter int unsigned BUF_DEPTH = 64,
  localparam int unsigned NBUF = rxe_pkg::NBUF,
  localparam int unsigned OFS_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  dma_en_i,
  input  logic                  xfer_vld_i,
  input  logic                  par_err_i,
  input  logic                  frm_err_i,
  input  logic                  buf_sel_i,
  input  logic [NBUF-1:0]       buf_start_i,
  input  logic                  ovf_evt_i,
  output logic [NBUF-1:0]       err_vld_o,
  output logic [NBUF*OFS_W-1:0] err_ofs_o,
  output logic                  rx_ovf_o
);
  import rxe_pkg::*;

  rxe_xfer_t xfer;
  logic      bad;

  assign xfer = '{vld: xfer_vld_i, par: par_err_i, frm: frm_err_i};
  assign bad  = xfer_bad(xfer);

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic             step;
    logic [OFS_W-1:0] cnt;

    assign step = xfer.vld && (buf_sel_i == SEL_W'(b));

    rxe_ofs_cnt #(.BUF_DEPTH(BUF_DEPTH)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (buf_start_i[b]),
      .step_i  (step),
      .cnt_o   (cnt)
    );

    rxe_first_cap #(.OFS_W(OFS_W)) u_cap (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (buf_start_i[b]),
      .step_i  (step),
      .bad_i   (bad),
      .cnt_i   (cnt),
      .vld_o   (err_vld_o[b]),
      .ofs_o   (err_ofs_o[b*OFS_W +: OFS_W])
    );
  end

  rxe_ovf_flag u_ovf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dma_en_i  (dma_en_i),
    .ovf_evt_i (ovf_evt_i),
    .ovf_o     (rx_ovf_o)
  );
endmodule

// File: rtl/rxe_err_ofs_chk.sv
module rxe_err_ofs_chk #(
  parameter int unsigned BUF_DEPTH = 64,
  localparam int unsigned NBUF = rxe_pkg::NBUF,
  localparam int unsigned OFS_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  dma_en_i,
  input logic                  xfer_vld_i,
  input logic                  par_err_i,
  input logic                  frm_err_i,
  input logic                  buf_sel_i,
  input logic [NBUF-1:0]       buf_start_i,
  input logic                  ovf_evt_i,
  input logic [NBUF-1:0]       err_vld_o,
  input logic [NBUF*OFS_W-1:0] err_ofs_o,
  input logic                  rx_ovf_o
);
  logic bad;
  assign bad = par_err_i | frm_err_i;

  for (genvar b = 0; b < NBUF; b++) begin : g_b
    logic to_me;
    assign to_me = xfer_vld_i && (buf_sel_i == 1'(b));

    AST_FIRST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (to_me && bad && !err_vld_o[b] && !buf_start_i[b]) |=> err_vld_o[b]); // R2

    AST_CAPTURE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_vld_o[b] && !buf_start_i[b]) |=> (err_vld_o[b] && $stable(err_ofs_o[b*OFS_W +: OFS_W]))); // R3

    AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (buf_start_i[b] && !(to_me && bad)) |=> (!err_vld_o[b] && err_ofs_o[b*OFS_W +: OFS_W] == '0)); // R4

    AST_START_HIT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (buf_start_i[b] && to_me && bad) |=> (err_vld_o[b] && err_ofs_o[b*OFS_W +: OFS_W] == '0)); // R6

    AST_OTHER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!to_me && !buf_start_i[b]) |=> ($stable(err_vld_o[b]) && $stable(err_ofs_o[b*OFS_W +: OFS_W]))); // R5
  end

  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_en_i && ovf_evt_i) |=> rx_ovf_o); // R7

  AST_OVF_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_ovf_o && !(dma_en_i && ovf_evt_i)) |=> !rx_ovf_o); // R7

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ovf_o && !dma_en_i) |=> rx_ovf_o); // R8
endmodule

bind rxe_err_ofs_trk rxe_err_ofs_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dma_en_i    (dma_en_i),
  .xfer_vld_i  (xfer_vld_i),
  .par_err_i   (par_err_i),
  .frm_err_i   (frm_err_i),
  .buf_sel_i   (buf_sel_i),
  .buf_start_i (buf_start_i),
  .ovf_evt_i   (ovf_evt_i),
  .err_vld_o   (err_vld_o),
  .err_ofs_o   (err_ofs_o),
  .rx_ovf_o    (rx_ovf_o)
);

// File: tb/sim_rxe_err_ofs_trk.sv
`timescale 1ns/1ps
module sim_rxe_err_ofs_trk;
  localparam int unsigned DEPTH = 64;
  localparam int unsigned OW = $clog2(DEPTH);
  localparam int unsigned CMAX = DEPTH - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic dma_en_i = 1'b0, xfer_vld_i = 1'b0, par_err_i = 1'b0, frm_err_i = 1'b0;
  logic buf_sel_i = 1'b0, ovf_evt_i = 1'b0;
  logic [1:0] buf_start_i = 2'b00;
  logic [1:0] err_vld_o;
  logic [2*OW-1:0] err_ofs_o;
  logic rx_ovf_o;

  always #2.5 clk_i = ~clk_i;

  rxe_err_ofs_trk #(.BUF_DEPTH(DEPTH)) u0 (.*);

  int n_chk = 0, n_bad = 0;
  logic [1:0] q_vld[$];
  logic [2*OW-1:0] q_ofs[$];
  logic q_ovf[$];
  string q_tag[$];

  int m_cnt[2];
  logic m_vld[2];
  logic [OW-1:0] m_ofs[2];
  logic m_ovf = 1'b0, m_en = 1'b0;

  task automatic step(input logic xv, input logic par, input logic frm, input logic sel,
                      input logic [1:0] st, input logic en, input logic ovf, input string tag);
    @(negedge clk_i);
    xfer_vld_i = xv; par_err_i = par; frm_err_i = frm; buf_sel_i = sel;
    buf_start_i = st; dma_en_i = en; ovf_evt_i = ovf;
    for (int b = 0; b < 2; b++) begin
      logic hit;
      hit = xv && (int'(sel) == b);
      if (st[b]) begin
        m_vld[b] = hit && (par || frm);
        m_ofs[b] = '0;
        m_cnt[b] = hit ? 1 : 0;
      end else if (hit) begin
        if ((par || frm) && !m_vld[b]) begin
          m_vld[b] = 1'b1;
          m_ofs[b] = OW'(m_cnt[b]);
        end
        if (m_cnt[b] != CMAX) m_cnt[b]++;
      end
    end
    if (en && ovf) m_ovf = 1'b1;
    else if (en && !m_en) m_ovf = 1'b0;
    m_en = en;
    q_vld.push_back({m_vld[1], m_vld[0]});
    q_ofs.push_back({m_ofs[1], m_ofs[0]});
    q_ovf.push_back(m_ovf);
    q_tag.push_back(tag);
  endtask

  // monitor
  always begin
    @(posedge clk_i);
    #1;
    if (q_tag.size() > 0) begin
      logic [1:0] ev;
      logic [2*OW-1:0] eo;
      logic ef;
      string t;
      ev = q_vld.pop_front(); eo = q_ofs.pop_front(); ef = q_ovf.pop_front(); t = q_tag.pop_front();
      n_chk++;
      if (err_vld_o !== ev || err_ofs_o !== eo || rx_ovf_o !== ef) begin
        n_bad++;
        $display("FAIL %s: vld=%b ofs=%h ovf=%b expected vld=%b ofs=%h ovf=%b",
                 t, err_vld_o, err_ofs_o, rx_ovf_o, ev, eo, ef);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    for (int b = 0; b < 2; b++) begin m_cnt[b] = 0; m_vld[b] = 1'b0; m_ofs[b] = '0; end
    repeat (3) @(posedge clk_i);
    #1;
    n_chk++;
    if (err_vld_o !== 2'b00 || err_ofs_o !== '0 || rx_ovf_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 reset: vld=%b ofs=%h ovf=%b expected 0 0 0", err_vld_o, err_ofs_o, rx_ovf_o);
    end
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 R2: fill A, first error (parity) at offset 5
    step(0, 0, 0, 0, 2'b01, 1, 0, "R1 start A");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 2'b00, 1, 0, "R1 clean byte A");
    step(1, 1, 0, 0, 2'b00, 1, 0, "R2 parity err A@5");
    // R3: later framing error does not overwrite
    step(1, 0, 1, 0, 2'b00, 1, 0, "R3 later err A");
    step(1, 1, 1, 0, 2'b00, 1, 0, "R3 both flags A");
    // R10: flags without strobe ignored
    step(0, 1, 1, 1, 2'b00, 1, 0, "R10 flags no strobe");
    // R6 R4: start B with erroneous byte same cycle -> offset 0
    step(1, 0, 1, 1, 2'b10, 1, 0, "R4 R6 start+err B@0");
    step(1, 0, 0, 1, 2'b00, 1, 0, "R1 clean byte B");
    // R5: start A while bad byte to B; B held
    step(1, 1, 0, 1, 2'b01, 1, 0, "R5 start A, err to B");
    step(1, 0, 0, 0, 2'b00, 1, 0, "R1 clean byte A@0");
    step(1, 0, 0, 0, 2'b00, 1, 0, "R1 clean byte A@1");
    step(1, 0, 1, 0, 2'b00, 1, 0, "R2 framing err A@2");
    step(0, 0, 0, 0, 2'b10, 1, 0, "R4 start B clears");
    step(1, 1, 0, 0, 2'b00, 1, 0, "R5 err to A leaves B");
    // R7 R8: overrun
    step(0, 0, 0, 0, 2'b00, 0, 1, "R7 ovf while DMA off");
    step(0, 0, 0, 0, 2'b00, 1, 0, "R8 enable rise no ovf");
    step(0, 0, 0, 0, 2'b00, 1, 1, "R7 ovf while DMA on");
    step(0, 0, 0, 0, 2'b00, 1, 0, "R8 sticky");
    step(0, 0, 0, 0, 2'b00, 0, 0, "R8 sticky DMA off");
    step(0, 0, 0, 0, 2'b00, 1, 0, "R8 cleared on enable rise");
    step(0, 0, 0, 0, 2'b00, 0, 0, "R8 DMA off");
    step(0, 0, 0, 0, 2'b00, 1, 1, "R8 rise+ovf sets");
    // R9: saturation
    step(0, 0, 0, 0, 2'b01, 1, 0, "R9 start A");
    for (int i = 0; i < DEPTH + 6; i++) step(1, 0, 0, 0, 2'b00, 1, 0, "R9 clean fill A");
    step(1, 0, 1, 0, 2'b00, 1, 0, "R9 err past end A@max");
    step(0, 0, 0, 0, 2'b00, 1, 0, "R9 idle");
    wait (q_tag.size() == 0);
    @(negedge clk_i);
    finish_run();
  end
endmodule